// File: doc/BRIEF.md
# Three-Dimensional Torus Node Router

This block routes fixed-size packets for a single node of a three-dimensional ring-wrapped grid. It has seven inbound and seven outbound valid/ready packet ports. One pair is the node's own injection and ejection port. The other six pairs face the neighbours at +X, −X, +Y, −Y, +Z and −Z. Every packet carries a destination coordinate for each axis.

The route is dimension-ordered. A packet first corrects its X coordinate, then Y, then Z. On each axis it travels the shorter way around the ring. Each axis has two holding queues, one for each direction of travel. A queue's head either leaves on that queue's own link or turns into a queue of a later axis. The local ejection port takes packets that have arrived at this node.

The write side of each queue, and the ejection port, is fed through a fixed-width round-robin selector:
- 2 inputs for an X queue;
- 3 inputs for a Y queue;
- 5 inputs for a Z queue;
- 7 inputs for ejection.

Nothing is ever dropped. A full queue withdraws ready from its selector, and the stall propagates back to the inbound ports.

Top module: `torus_node_router`

## Requirements
- R1: A packet is an unsigned vector `{payload, z, y, x}`, with destination x in bits [CW-1:0], y in [2CW-1:CW] and z in [3CW-1:2CW]. A packet whose destination equals (OWN_X, OWN_Y, OWN_Z) leaves on outbound port 0 (ejection) unchanged.
- R2: Port indices are 0 = local, 1 = +X, 2 = −X, 3 = +Y, 4 = −Y, 5 = +Z, 6 = −Z. A packet that enters on an axis port starts on that axis. It leaves on the link of the first axis, from its entry axis onward in the order X, Y, Z, whose coordinate differs from the node's own. A locally injected packet starts on X.
- R3: On the chosen axis, let delta = (dest − own) mod SIZE. If delta ≤ SIZE/2, the packet leaves on the + link. Otherwise it leaves on the − link. A distance of exactly SIZE/2 therefore goes +.
- R4: Once an outbound link port raises valid, valid stays high and the data stays unchanged until that port's ready is high at a clock edge.
- R5: No packet is lost or duplicated. While an outbound link is stalled, its queue fills, and the inbound port feeding that queue then holds ready low. Packets on one path leave in the order they arrived.
- R6: When several sources compete for the same queue or for ejection, grants rotate round-robin. Two sources that both keep requesting are served alternately.
- R7: After synchronous reset every outbound valid is low.
- R8: A locally injected packet addressed to this node goes straight to ejection without passing through a queue.
- R9: A locally injected packet with no X distance but a Y or Z distance leaves on the proper Y or Z link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 7 | Inbound packet valid, one bit per port index |
| in_ready | output | 7 | Inbound packet accepted this cycle, one bit per port index |
| in_data | input | 7 × PKT_W | Inbound packets, one per port index |
| out_valid | output | 7 | Outbound packet valid, one bit per port index |
| out_ready | input | 7 | Outbound sink can take the packet, one bit per port index |
| out_data | output | 7 × PKT_W | Outbound packets, one per port index |

## Verification
The assertions take two things for granted about the inbound traffic:
- A packet arriving on an axis port has already matched the node's coordinates on every earlier axis, and it travels the direction of the port it came in on. Only under this condition does every outbound link packet show matching lower axes and a differing own axis.
- Inbound valid holds, with the data steady, until ready.

The stimulus respects both. Transit packets are only sent on an axis whose earlier coordinates already equal the node's (1,1,1). Each driver task raises valid and keeps it up until it has seen ready.

// File: rtl/torus_router_pkg.sv
package torus_router_pkg;

    localparam int NPORT = 7;          // local + six links
    localparam int NFIFO = 6;          // two per axis
    localparam int HB    = NPORT;      // first head-source index in a take row
    localparam int NSRC  = NPORT + NFIFO;

    typedef int coord3_t [3];

    // 0: already there, 1: plus way, 2: minus way
    function automatic int ring_step(int own, int dst, int size);
        int delta;
        delta = ((dst - own) % size + size) % size;
        if (delta == 0)
            return 0;
        else if (delta <= size / 2)
            return 1;
        else
            return 2;
    endfunction

    // target code: 0 = eject, 1..6 = link/queue index as port numbering
    function automatic int next_hop(coord3_t dst, coord3_t own,
                                    coord3_t size, int start);
        for (int d = start; d < 3; d++) begin
            int st;
            st = ring_step(own[d], dst[d], size[d]);
            if (st != 0)
                return 1 + 2 * d + (st - 1);
        end
        return 0;
    endfunction

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         en,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    int            sel;

    always_comb begin
        logic found;
        gnt   = '0;
        sel   = 0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (int'(ptr) + i) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                sel      = idx;
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (en && (|req))
            ptr <= (sel == N - 1) ? '0 : IW'(sel + 1);
    end

    // R6
    gnt_legal_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt & ~req) == '0));

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   count;

    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/hop_decode.sv
module hop_decode
    import torus_router_pkg::*;
#(
    parameter int CW     = 2,
    parameter int SIZE_X = 4,
    parameter int SIZE_Y = 4,
    parameter int SIZE_Z = 4,
    parameter int OWN_X  = 1,
    parameter int OWN_Y  = 1,
    parameter int OWN_Z  = 1,
    parameter int START  = 0
) (
    input  logic [3*CW-1:0] dest,
    output logic [2:0]      tgt
);
    always_comb begin
        coord3_t d, o, s;
        d[0] = int'(dest[CW-1:0]);
        d[1] = int'(dest[2*CW-1:CW]);
        d[2] = int'(dest[3*CW-1:2*CW]);
        o[0] = OWN_X;  o[1] = OWN_Y;  o[2] = OWN_Z;
        s[0] = SIZE_X; s[1] = SIZE_Y; s[2] = SIZE_Z;
        tgt  = 3'(next_hop(d, o, s, START));
    end

endmodule

// File: rtl/torus_node_router.sv
module torus_node_router
    import torus_router_pkg::*;
#(
    parameter int CW     = 2,
    parameter int SIZE_X = 4,
    parameter int SIZE_Y = 4,
    parameter int SIZE_Z = 4,
    parameter int OWN_X  = 1,
    parameter int OWN_Y  = 1,
    parameter int OWN_Z  = 1,
    parameter int PAY_W  = 8,
    parameter int DEPTH  = 4,
    localparam int PKT_W = 3 * CW + PAY_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPORT-1:0]            in_valid,
    output logic [NPORT-1:0]            in_ready,
    input  logic [NPORT-1:0][PKT_W-1:0] in_data,
    output logic [NPORT-1:0]            out_valid,
    input  logic [NPORT-1:0]            out_ready,
    output logic [NPORT-1:0][PKT_W-1:0] out_data
);
    localparam logic [3*CW-1:0] OWN_V = {CW'(OWN_Z), CW'(OWN_Y), CW'(OWN_X)};

    logic [NFIFO-1:0]            f_empty, f_full, f_push, f_pop;
    logic [PKT_W-1:0]            f_head  [NFIFO];
    logic [PKT_W-1:0]            f_wdata [NFIFO];
    logic [2:0]                  h_tgt   [NFIFO];
    logic [2:0]                  loc_raw, loc_tgt;
    logic [NPORT-1:0][NSRC-1:0]  take;
    logic                        ej_valid;
    logic [PKT_W-1:0]            ej_data;

    // local injection: straight to eject, else into an X queue
    hop_decode #(
        .CW(CW), .SIZE_X(SIZE_X), .SIZE_Y(SIZE_Y), .SIZE_Z(SIZE_Z),
        .OWN_X(OWN_X), .OWN_Y(OWN_Y), .OWN_Z(OWN_Z), .START(0)
    ) u_loc_dec (
        .dest(in_data[0][3*CW-1:0]),
        .tgt (loc_raw)
    );
    assign loc_tgt = (loc_raw == 3'd0) ? 3'd0 :
                     (loc_raw <= 3'd2) ? loc_raw : 3'd1;

    // standby queues and their head decoders
    for (genvar k = 0; k < NFIFO; k++) begin : g_q
        pkt_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_fifo (
            .clk  (clk),
            .rst  (rst),
            .push (f_push[k]),
            .wdata(f_wdata[k]),
            .pop  (f_pop[k]),
            .head (f_head[k]),
            .empty(f_empty[k]),
            .full (f_full[k])
        );
        hop_decode #(
            .CW(CW), .SIZE_X(SIZE_X), .SIZE_Y(SIZE_Y), .SIZE_Z(SIZE_Z),
            .OWN_X(OWN_X), .OWN_Y(OWN_Y), .OWN_Z(OWN_Z), .START(k / 2)
        ) u_dec (
            .dest(f_head[k][3*CW-1:0]),
            .tgt (h_tgt[k])
        );
    end

    // queue write selectors: 2:1 on X, 3:1 on Y, 5:1 on Z
    for (genvar k = 0; k < NFIFO; k++) begin : g_wr
        localparam int D = k / 2;
        localparam int C = k + 1;
        localparam int N = (D == 0) ? 2 : 2 * D + 1;

        logic [N-1:0]     req, gnt;
        logic             acc;
        logic [NSRC-1:0]  row;
        logic [PKT_W-1:0] wd;

        if (D == 0) begin : g_xsrc
            always_comb begin
                req[0] = in_valid[0] && (loc_tgt == 3'(C));
                req[1] = in_valid[C];
            end
        end else begin : g_turn
            always_comb begin
                for (int j = 0; j < 2 * D; j++)
                    req[j] = !f_empty[j] && (h_tgt[j] == 3'(C));
                req[N-1] = in_valid[C];
            end
        end

        assign acc = (|req) && !f_full[k];

        rr_arbiter #(.N(N)) u_arb (
            .clk(clk), .rst(rst), .req(req), .en(acc), .gnt(gnt)
        );

        always_comb begin
            wd  = '0;
            row = '0;
            for (int j = 0; j < N; j++) begin
                if (gnt[j]) begin
                    if (j == N - 1) begin
                        wd     = in_data[C];
                        row[C] = acc;
                    end else if (D == 0) begin
                        wd     = in_data[0];
                        row[0] = acc;
                    end else begin
                        wd          = f_head[j];
                        row[HB + j] = acc;
                    end
                end
            end
        end

        assign take[C]    = row;
        assign f_push[k]  = acc;
        assign f_wdata[k] = wd;
    end

    // ejection selector: 7:1 over six queue heads and the local bypass
    logic [NPORT-1:0] ej_req, ej_gnt;
    logic             ej_acc;
    logic [NSRC-1:0]  ej_row;

    always_comb begin
        for (int j = 0; j < NFIFO; j++)
            ej_req[j] = !f_empty[j] && (h_tgt[j] == 3'd0);
        ej_req[NPORT-1] = in_valid[0] && (loc_tgt == 3'd0);
    end

    assign ej_valid = |ej_req;
    assign ej_acc   = ej_valid && out_ready[0];

    rr_arbiter #(.N(NPORT)) u_ej_arb (
        .clk(clk), .rst(rst), .req(ej_req), .en(ej_acc), .gnt(ej_gnt)
    );

    always_comb begin
        ej_data = '0;
        ej_row  = '0;
        for (int j = 0; j < NPORT; j++) begin
            if (ej_gnt[j]) begin
                if (j == NPORT - 1) begin
                    ej_data   = in_data[0];
                    ej_row[0] = ej_acc;
                end else begin
                    ej_data        = f_head[j];
                    ej_row[HB + j] = ej_acc;
                end
            end
        end
    end
    assign take[0] = ej_row;

    // outbound ports
    always_comb begin
        out_valid[0] = ej_valid;
        out_data[0]  = ej_data;
        for (int c = 1; c < NPORT; c++) begin
            out_valid[c] = !f_empty[c-1] && (h_tgt[c-1] == 3'(c));
            out_data[c]  = f_head[c-1];
        end
    end

    // queue pops and inbound ready
    always_comb begin
        for (int k = 0; k < NFIFO; k++) begin
            f_pop[k] = out_valid[k+1] && out_ready[k+1];
            for (int t = 0; t < NPORT; t++)
                f_pop[k] = f_pop[k] | take[t][HB + k];
        end
        for (int p = 0; p < NPORT; p++) begin
            in_ready[p] = 1'b0;
            for (int t = 0; t < NPORT; t++)
                in_ready[p] = in_ready[p] | take[t][p];
        end
    end

    // R1
    eject_addr_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid[0] |-> (out_data[0][3*CW-1:0] == OWN_V));

    for (genvar c = 1; c < NPORT; c++) begin : g_chk
        localparam int D = (c - 1) / 2;
        logic order_ok;
        always_comb begin
            order_ok = (out_data[c][D*CW +: CW] != OWN_V[D*CW +: CW]);
            for (int e = 0; e < D; e++)
                if (out_data[c][e*CW +: CW] != OWN_V[e*CW +: CW])
                    order_ok = 1'b0;
        end
        // R4
        link_hold_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid[c] && !out_ready[c] |=> out_valid[c] && $stable(out_data[c]));
        // R2
        dim_order_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid[c] |-> order_ok);
    end

endmodule

// File: tb/tb_torus_node_router.sv
`timescale 1ns/1ps
module tb_torus_node_router;
    localparam int CW  = 2;
    localparam int PAY = 8;
    localparam int PW  = 3 * CW + PAY;
    localparam int NP  = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                   rst;
    logic [NP-1:0]          in_valid, in_ready, out_valid, out_ready;
    logic [NP-1:0][PW-1:0]  in_data, out_data;

    torus_node_router dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit r5_sent = 1'b0;

    logic [PW-1:0]  expq [NP][$];
    string          tagq [NP][$];
    logic [PAY-1:0] ej_log[$];
    logic [PAY-1:0] x_log[$];
    logic [PAY-1:0] held;

    function automatic logic [PW-1:0] mk(int x, int y, int z, int pay);
        return {PAY'(pay), CW'(z), CW'(y), CW'(x)};
    endfunction

    // model: ring of 4, own node (1,1,1), half-way goes plus
    function automatic int step_of(int own, int dst);
        int delta;
        delta = (dst - own + 4) % 4;
        if (delta == 0) return 0;
        return (delta <= 2) ? 1 : 2;
    endfunction

    function automatic int exp_port(int src, int x, int y, int z);
        int c[3];
        int start;
        c[0] = x; c[1] = y; c[2] = z;
        start = (src == 0) ? 0 : (src - 1) / 2;
        for (int d = start; d < 3; d++) begin
            int st;
            st = step_of(1, c[d]);
            if (st != 0) return 1 + 2 * d + (st - 1);
        end
        return 0;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(int p, int x, int y, int z, int pay, string tag);
        int op;
        op = exp_port(p, x, y, z);
        @(posedge clk); #1;
        in_data[p]  = mk(x, y, z, pay);
        in_valid[p] = 1'b1;
        expq[op].push_back(mk(x, y, z, pay));
        tagq[op].push_back(tag);
        do @(negedge clk); while (!in_ready[p]);
        @(posedge clk); #1;
        in_valid[p] = 1'b0;
    endtask

    // monitor: every delivered packet must be an expected one on that port
    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NP; p++) begin
                if (out_valid[p] && out_ready[p]) begin
                    int hit;
                    hit = -1;
                    for (int i = 0; i < expq[p].size(); i++)
                        if (hit < 0 && expq[p][i] == out_data[p]) hit = i;
                    checks++;
                    if (hit < 0) begin
                        errors++;
                        $display("FAIL R2 unexpected packet on port %0d actual=%0h expected=none",
                                 p, out_data[p]);
                    end else begin
                        expq[p].delete(hit);
                        tagq[p].delete(hit);
                    end
                    if (p == 0) ej_log.push_back(out_data[p][PW-1:3*CW]);
                    if (p == 1) x_log.push_back(out_data[p][PW-1:3*CW]);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst       = 1'b1;
        in_valid  = '0;
        in_data   = '0;
        out_ready = '1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == '0, "R7 outputs idle after reset", int'(out_valid), 0);

        // basic routing, one at a time
        send(0, 1, 1, 1, 8'h01, "R8 self-addressed local injection");
        send(0, 3, 1, 1, 8'h02, "R3 half ring goes plus");
        send(0, 0, 1, 1, 8'h03, "R3 shorter way is minus");
        send(0, 1, 3, 1, 8'h04, "R9 local with Y distance only");
        send(0, 1, 1, 0, 8'h05, "R9 local with Z distance only");
        send(0, 2, 3, 0, 8'h0A, "R2 X corrected first");
        send(1, 1, 0, 2, 8'h06, "R2 X arrival turns to -Y");
        send(4, 1, 1, 2, 8'h07, "R2 Y arrival turns to +Z");
        send(5, 1, 1, 1, 8'h08, "R1 Z arrival ejects");
        send(2, 0, 1, 1, 8'h09, "R3 transit keeps minus");
        send(6, 1, 1, 0, 8'h0B, "R2 transit keeps -Z");
        repeat (12) @(negedge clk);
        for (int p = 0; p < NP; p++)
            check(expq[p].size() == 0, "R2 basic packets delivered", expq[p].size(), 0);

        // R5 / R4: stall +X link, overfill its queue
        x_log.delete();
        @(posedge clk); #1 out_ready[1] = 1'b0;
        fork
            begin
                for (int i = 0; i < 6; i++)
                    send(0, 3, 1, 1, 8'h10 + i, "R5 stalled path");
                r5_sent = 1'b1;
            end
        join_none
        repeat (30) @(negedge clk);
        check(in_valid[0] && !in_ready[0], "R5 inbound ready low when queue full",
              int'(in_ready[0]), 0);
        check(out_valid[1] == 1'b1, "R4 stalled link keeps valid", int'(out_valid[1]), 1);
        held = out_data[1][PW-1:3*CW];
        check(held == 8'h10, "R5 oldest packet at link head", int'(held), 8'h10);
        repeat (3) @(negedge clk);
        check(out_valid[1] && out_data[1][PW-1:3*CW] == held, "R4 stalled link data stable",
              int'(out_data[1][PW-1:3*CW]), int'(held));
        @(posedge clk); #1 out_ready[1] = 1'b1;
        wait (r5_sent);
        repeat (12) @(negedge clk);
        check(x_log.size() == 6, "R5 all stalled packets delivered", x_log.size(), 6);
        for (int i = 0; i < x_log.size(); i++)
            check(x_log[i] == PAY'(8'h10 + i), "R5 order kept on one path",
                  int'(x_log[i]), 8'h10 + i);

        // R6: two queue heads compete for ejection
        @(posedge clk); #1 out_ready[0] = 1'b0;
        fork
            begin
                for (int i = 0; i < 3; i++) send(1, 1, 1, 1, 8'hA0 + i, "R6 from +X queue");
            end
            begin
                for (int i = 0; i < 3; i++) send(3, 1, 1, 1, 8'hB0 + i, "R6 from +Y queue");
            end
        join
        repeat (5) @(negedge clk);
        ej_log.delete();
        @(posedge clk); #1 out_ready[0] = 1'b1;
        repeat (20) @(negedge clk);
        check(ej_log.size() == 6, "R6 all competing packets ejected", ej_log.size(), 6);
        for (int i = 1; i < ej_log.size(); i++)
            check(ej_log[i][7:4] != ej_log[i-1][7:4], "R6 ejection alternates sources",
                  int'(ej_log[i]), int'(ej_log[i-1]));

        for (int p = 0; p < NP; p++)
            check(expq[p].size() == 0, "R5 nothing lost at end", expq[p].size(), 0);
        finish_run();
    end

endmodule